// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides whether a received Ethernet frame is kept or dropped, judging by the 48-bit destination address that leads the frame. The receive path marks the start of each frame with a one-cycle strobe. It then hands over the six destination bytes one at a time, each qualified by a byte-valid signal. Idle cycles between bytes are allowed. One clock edge after the sixth byte is taken, the block raises a decision-valid pulse for a single cycle, and the accept flag beside it gives the verdict.

Unicast destinations must match the station address exactly. Group (multicast) destinations pass in one of three ways: all of them pass, none of them pass, or each is looked up in a 64-bin hash table indexed by the top six bits of a CRC-32 over the destination. The all-ones broadcast address has its own rule. A promiscuous control overrides everything else. The mode bits, the station address and the hash table are all captured at the start strobe, so software may rewrite them while a frame is in flight.

Top module: `rxaf_top`

## Requirements
- R1: After reset, dec_vld_o and accept_o are 0. Address bytes that arrive before any start strobe produce no decision.
- R2: dec_vld_o is high for exactly one cycle. That cycle follows the clock edge that takes the sixth address byte. Idle cycles between bytes are allowed, and further bytes before the next start strobe are ignored.
- R3: A start strobe restarts byte counting and the CRC, which also abandons a partial frame. A byte presented in the same cycle as the strobe counts as the first address byte.
- R4: The first byte received is address byte 0 and sits in bits 7:0 of the address vectors (station_addr_i uses the same layout). The address is a group address when bit 0 of byte 0 is 1.
- R5: With the promiscuous control set, every frame is accepted, whatever the address and the other controls.
- R6: The all-ones address is accepted when the broadcast-block control is 0 and rejected when it is 1. Only the promiscuous control overrides this rule.
- R7: A unicast destination is accepted exactly when it equals the station address, in every mode except promiscuous.
- R8: With the pass-all-multicast control set, every non-broadcast group address is accepted without reference to the hash table.
- R9: With hash mode set and pass-all-multicast clear, a non-broadcast group address is accepted when table bit k is 1. The table is {hash_hi_i, hash_lo_i}. The index k is bits 31:26 of a CRC over the six bytes in arrival order, taking each byte LSB first, with polynomial 0x04C11DB7, a start value of 0xFFFFFFFF and no final inversion. Bit 5 of k therefore selects hash_hi_i (1) or hash_lo_i (0), and bits 4:0 select the bit within that word.
- R10: With hash mode and pass-all-multicast both clear, non-broadcast group addresses are rejected. With hash mode set and both words all ones, all of them are accepted.
- R11: The controls, station address and hash words are sampled at the start strobe. Changing them afterwards has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame strobe |
| byte_vld_i | input | 1 | Address byte valid |
| byte_i | input | 8 | Address byte |
| station_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_hi_i | input | 32 | Hash table bins 63..32 |
| hash_lo_i | input | 32 | Hash table bins 31..0 |
| promisc_i | input | 1 | Accept every frame |
| pass_mcast_i | input | 1 | Accept every group address |
| hash_mode_i | input | 1 | Filter group addresses through the hash table |
| bcast_block_i | input | 1 | Reject the broadcast address |
| accept_o | output | 1 | Verdict, held until the next decision |
| dec_vld_o | output | 1 | One-cycle decision strobe |

## Verification
The assertions assume that every input carries a known 0 or 1 at each clock edge. They also assume that the start strobe is a pulse and is not held high across a frame. The stimulus drives all inputs on the falling edge and holds each one for whole cycles. It raises the start strobe for one cycle only, either alone or together with the first byte. Configuration is changed mid-frame only in the deliberate R11 sequence.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = 8 * ADDR_BYTES;
    localparam int CNT_W       = $clog2(ADDR_BYTES + 1);
    localparam int HASH_IDX_W  = 6;
    localparam int HASH_BINS   = 1 << HASH_IDX_W;
    localparam int HASH_WORD_W = HASH_BINS / 2;
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic                  promisc;
        logic                  pass_mcast;
        logic                  hash_mode;
        logic                  bcast_block;
        logic [ADDR_W-1:0]     station;
        logic [HASH_BINS-1:0]  hash_tbl;
    } filt_cfg_t;

    // one byte into a left-shifting CRC, data taken LSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxaf_collect.sv
module rxaf_collect
    import rxaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic              vld,
    input  logic [7:0]        data,
    output logic              take,
    output logic              last,
    output logic [ADDR_W-1:0] dest
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [7:0]       hold_q [ADDR_BYTES-1];

    assign base = sof ? '0 : cnt_q;
    assign take = vld && (base < CNT_W'(ADDR_BYTES));
    assign last = take && (base == CNT_W'(ADDR_BYTES - 1));

    // idle count is ADDR_BYTES: bytes are ignored until a start strobe
    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= CNT_W'(ADDR_BYTES);
        else if (take) cnt_q <= base + 1'b1;
        else if (sof)  cnt_q <= '0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ADDR_BYTES - 1; i++) begin
            if (rst)                                hold_q[i] <= '0;
            else if (take && base == CNT_W'(i))     hold_q[i] <= data;
        end
    end

    for (genvar g = 0; g < ADDR_BYTES - 1; g++) begin : g_dest
        assign dest[8*g +: 8] = hold_q[g];
    end
    assign dest[ADDR_W-1 -: 8] = data;

endmodule

// File: rtl/rxaf_crc.sv
module rxaf_crc
    import rxaf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  en,
    input  logic [7:0]            data,
    output logic [HASH_IDX_W-1:0] idx
);
    logic [CRC_W-1:0] crc_q, seed, crc_nx;

    assign seed   = clr ? CRC_INIT : crc_q;
    assign crc_nx = en ? crc_step(seed, data) : seed;
    assign idx    = crc_nx[CRC_W-1 -: HASH_IDX_W];

    always_ff @(posedge clk) begin
        if (rst)             crc_q <= CRC_INIT;
        else if (clr || en)  crc_q <= crc_nx;
    end

endmodule

// File: rtl/rxaf_judge.sv
module rxaf_judge
    import rxaf_pkg::*;
(
    input  logic [ADDR_W-1:0]     dest,
    input  logic [HASH_IDX_W-1:0] idx,
    input  filt_cfg_t             cfg,
    output logic                  accept
);
    logic is_bcast, is_group, exact, hash_hit;

    assign is_bcast = &dest;
    assign is_group = dest[0];
    assign exact    = (dest == cfg.station);
    assign hash_hit = cfg.hash_tbl[idx];

    always_comb begin
        if (cfg.promisc)          accept = 1'b1;
        else if (is_bcast)        accept = !cfg.bcast_block;
        else if (is_group) begin
            if (cfg.pass_mcast)     accept = 1'b1;
            else if (cfg.hash_mode) accept = hash_hit;
            else                    accept = 1'b0;
        end
        else                      accept = exact;
    end

endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
    import rxaf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sof_i,
    input  logic                   byte_vld_i,
    input  logic [7:0]             byte_i,
    input  logic [ADDR_W-1:0]      station_addr_i,
    input  logic [HASH_WORD_W-1:0] hash_hi_i,
    input  logic [HASH_WORD_W-1:0] hash_lo_i,
    input  logic                   promisc_i,
    input  logic                   pass_mcast_i,
    input  logic                   hash_mode_i,
    input  logic                   bcast_block_i,
    output logic                   accept_o,
    output logic                   dec_vld_o
);
    filt_cfg_t             cfg_q;
    logic                  take, last, verdict;
    logic [ADDR_W-1:0]     dest;
    logic [HASH_IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (sof_i) begin
            cfg_q.promisc     <= promisc_i;
            cfg_q.pass_mcast  <= pass_mcast_i;
            cfg_q.hash_mode   <= hash_mode_i;
            cfg_q.bcast_block <= bcast_block_i;
            cfg_q.station     <= station_addr_i;
            cfg_q.hash_tbl    <= {hash_hi_i, hash_lo_i};
        end
    end

    rxaf_collect u_collect (
        .clk(clk), .rst(rst), .sof(sof_i), .vld(byte_vld_i), .data(byte_i),
        .take(take), .last(last), .dest(dest)
    );

    rxaf_crc u_crc (
        .clk(clk), .rst(rst), .clr(sof_i), .en(take), .data(byte_i), .idx(idx)
    );

    rxaf_judge u_judge (
        .dest(dest), .idx(idx), .cfg(cfg_q), .accept(verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld_o <= 1'b0;
            accept_o  <= 1'b0;
        end else begin
            dec_vld_o <= last;
            if (last) accept_o <= verdict;
        end
    end

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker
    import rxaf_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sof_i,
    input logic      byte_vld_i,
    input logic      dec_vld_o,
    input logic      accept_o,
    input filt_cfg_t cfg_q
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dec_vld_o);

    p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        dec_vld_o |=> !dec_vld_o);

    p_after_byte_r2: assert property (@(posedge clk) disable iff (rst)
        dec_vld_o |-> $past(byte_vld_i));

    p_promisc_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_vld_o && cfg_q.promisc && !$past(sof_i)) |-> accept_o);

    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !sof_i |=> $stable(cfg_q));

endmodule

bind rxaf_top rxaf_checker u_chk (
    .clk(clk), .rst(rst), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
    .dec_vld_o(dec_vld_o), .accept_o(accept_o), .cfg_q(cfg_q)
);

// File: tb/tb_rxaf_top.sv
`timescale 1ns/1ps
module tb_rxaf_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0;
    logic        bvld = 1'b0;
    logic [7:0]  bdat = '0;
    logic [47:0] station = 48'h6655_4433_2210;
    logic [31:0] hhi = '0, hlo = '0;
    logic        prom = 1'b0, pmc = 1'b0, hmode = 1'b0, bblk = 1'b0;
    logic        accept, dvld;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    rxaf_top dut (
        .clk(clk), .rst(rst), .sof_i(sof), .byte_vld_i(bvld), .byte_i(bdat),
        .station_addr_i(station), .hash_hi_i(hhi), .hash_lo_i(hlo),
        .promisc_i(prom), .pass_mcast_i(pmc), .hash_mode_i(hmode),
        .bcast_block_i(bblk), .accept_o(accept), .dec_vld_o(dvld)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            fb = c[31] ^ a[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c[31:26];
    endfunction

    function automatic void model(input logic [47:0] a, output logic e,
                                  output string tag);
        logic [63:0] tbl;
        tbl = {hhi, hlo};
        if (prom)            begin e = 1'b1;  tag = "R5 promiscuous"; end
        else if (&a)         begin e = !bblk; tag = "R6 broadcast"; end
        else if (a[0]) begin
            if (pmc)         begin e = 1'b1;  tag = "R8 pass-all-multicast"; end
            else if (hmode)  begin e = tbl[hidx(a)]; tag = "R9 hash lookup"; end
            else             begin e = 1'b0;  tag = "R10 group rejected"; end
        end
        else                 begin e = (a == station); tag = "R7 unicast exact"; end
    endfunction

    task automatic put_byte(input logic [7:0] b);
        bvld = 1'b1;
        bdat = b;
        @(negedge clk);
        bvld = 1'b0;
        sof  = 1'b0;
    endtask

    task automatic run_frame(input logic [47:0] a, input bit sof_with, input int gap);
        logic  e;
        string tag;
        model(a, e, tag);
        if (!sof_with) begin
            sof = 1'b1;
            @(negedge clk);
            sof = 1'b0;
        end
        for (int i = 0; i < 6; i++) begin
            if (sof_with && i == 0) sof = 1'b1;
            put_byte(a[8*i +: 8]);
            if (i < 5) begin
                chk(dvld == 1'b0, "R2 early decision", 64'(dvld), 0);
                for (int g = 0; g < gap; g++) @(negedge clk);
            end
        end
        chk(dvld == 1'b1, "R2 decision strobe", 64'(dvld), 1);
        chk(accept == e, tag, 64'(accept), 64'(e));
        @(negedge clk);
        chk(dvld == 1'b0, "R2 single-cycle strobe", 64'(dvld), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] addrs [6];
        addrs[0] = 48'h6655_4433_2210;
        addrs[1] = 48'h6654_4433_2210;
        addrs[2] = 48'hFFFF_FFFF_FFFF;
        addrs[3] = 48'h0100_005E_0001;
        addrs[4] = 48'h3412_90AB_CD33;
        addrs[5] = 48'h0A0B_0C0D_0E02;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(dvld == 1'b0 && accept == 1'b0, "R1 reset outputs", {dvld, accept}, 0);

        // R1: bytes with no start strobe give no decision
        for (int i = 0; i < 8; i++) begin
            put_byte(8'hFF);
            chk(dvld == 1'b0, "R1 no strobe no decision", 64'(dvld), 0);
        end

        // R4..R8, R10: every mode combination against several address kinds
        hhi = 32'hA5C3_0F96;
        hlo = 32'h1234_F0E1;
        for (int m = 0; m < 16; m++) begin
            prom = m[0]; pmc = m[1]; hmode = m[2]; bblk = m[3];
            for (int a = 0; a < 6; a++) run_frame(addrs[a], a[0], m % 3);
        end

        // R9: walk a single set bin over the whole table
        prom = 0; pmc = 0; hmode = 1; bblk = 0;
        for (int b = 0; b < 64; b++) begin
            {hhi, hlo} = 64'd1 << b;
            for (int k = 0; k < 4; k++) begin
                logic [47:0] r;
                r = {$urandom, $urandom};
                r[0] = 1'b1;
                if (k == 0) r = addrs[3];
                run_frame(r, 1'b0, 0);
            end
        end

        // R10: all-ones table accepts any group address
        hhi = '1; hlo = '1;
        for (int k = 0; k < 8; k++) begin
            logic [47:0] r;
            r = {$urandom, $urandom};
            r[0] = 1'b1;
            run_frame(r, k[0], 0);
            chk(accept == 1'b1, "R10 full table", 64'(accept), 1);
        end

        // R3: abandon a partial frame, then a complete one
        hhi = '0; hlo = '0; hmode = 0;
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        put_byte(8'h01); put_byte(8'h02); put_byte(8'h03);
        run_frame(station, 1'b0, 0);
        chk(accept == 1'b1, "R3 restart then station match", 64'(accept), 1);
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        put_byte(8'hAA); put_byte(8'hBB);
        run_frame(addrs[5], 1'b1, 1);
        chk(accept == 1'b0, "R3 restart with byte on strobe", 64'(accept), 0);

        // R2: bytes after the sixth are ignored
        run_frame(station, 1'b0, 2);
        for (int i = 0; i < 4; i++) begin
            put_byte(8'h10);
            chk(dvld == 1'b0, "R2 surplus bytes ignored", 64'(dvld), 0);
        end

        // R11: promiscuous dropped after the strobe still applies
        prom = 1;
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        prom = 0; station = 48'h0;
        for (int i = 0; i < 6; i++) put_byte(addrs[5][8*i +: 8]);
        chk(dvld == 1'b1 && accept == 1'b1, "R11 sampled promiscuous",
            {dvld, accept}, 3);
        @(negedge clk);

        // R11: station changed to match after the strobe has no effect
        station = 48'h6655_4433_2210;
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        station = addrs[5]; prom = 1; bblk = 1;
        for (int i = 0; i < 6; i++) put_byte(addrs[5][8*i +: 8]);
        chk(dvld == 1'b1 && accept == 1'b0, "R11 sampled station",
            {dvld, accept}, 2);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule